// File: doc/BRIEF.md
# Nearest-Neighbour Coefficient Table Loader

This block programs a polyphase scaler's coefficient RAM so that the scaler passes the nearest source sample straight through. It does this through a two-register write port. One register is an index/control register. The other is a data register, which stores into the RAM at the current index. One pulse on `start` runs the whole sequence. First the index register is written with the auto-increment flag set and the address at zero. Next comes one data write per packed coefficient word. Last, the index register is written back to zero. The sequencer then drops `busy` and raises `done` for one cycle.

The table covers 17 phases of 7 taps, which is 119 sixteen-bit coefficients. Two coefficients are packed into each 32-bit word, so the table takes 60 words. The coefficient with linear number i belongs to tap (i mod 7). Tap 3 is the centre tap and gets unity gain, coded 0x0800. Every other tap gets the coded zero, 0x3000. The project contains a model of the target RAM, with its index register and auto-increment. The model can be stalled through its ready signal. Its contents can be read back through a separate read port.

The sequencer has four states:
- IDLE waits for `start`. The transition IDLE→ARM happens when `start` is seen.
- ARM requests the index write that turns auto-increment on. The transition ARM→FILL happens when that write is accepted.
- FILL requests the data writes. The transition FILL→CLEAR happens when the 60th data write is accepted.
- CLEAR requests the zero index write. The transition CLEAR→IDLE happens when that write is accepted, and `done` pulses at that point.

Top module: `nn_coef_loader`

## Requirements
- R1: After reset, `busy`, `done` and `bus_wr` are 0, and the index register value `idx_value` is 0.
- R2: The first accepted write after `start` goes to the index register (`bus_sel`=0). Its value has bit 10 (the auto-increment flag) set and address bits [5:0] equal to 0, so the value is 0x400.
- R3: Exactly 60 data writes (`bus_sel`=1) follow. Word w holds coefficient 2w in bits [15:0] and coefficient 2w+1 in bits [31:16]. Coefficient i has tap i mod 7; tap 3 gets 0x0800 and every other tap gets 0x3000.
- R4: The last word, at address 59, has its upper half reserved and written as 0x0000. Its lower half is tap 6, so the word is 0x00003000.
- R5: The last accepted write goes to the index register with value 0. After the sequence ends, `idx_value` reads 0.
- R6: `busy` is high from the cycle after `start` until the last index write is accepted. `done` is high for exactly one cycle, in the cycle where `busy` falls. With no stalls, `done` appears 63 cycles after `start`.
- R7: A `start` pulse while `busy` is high is ignored. The sequence still performs exactly 2 index writes and 60 data writes, and `done` pulses once.
- R8: While `bus_rdy` is low, the pending request holds its `bus_sel` and `bus_wdata` unchanged and is not lost. Driving `ram_stall` high forces `bus_rdy` low. A stalled run leaves the same RAM contents as a run without stalls.
- R9: While the auto-increment flag is set, each data write stores at the current index and then advances the index by one. No data write is made at an index of 60 or above.
- R10: `rd_data` shows the RAM word at `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin loading the table |
| ram_stall | input | 1 | Forces the RAM model's ready low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_wr | output | 1 | Write request on the register port |
| bus_sel | output | 1 | 0 selects the index register, 1 the data register |
| bus_wdata | output | 32 | Write data |
| bus_rdy | output | 1 | RAM model accepts the write this cycle |
| idx_value | output | 11 | Index register contents: flag in bit 10, address in the low bits |
| rd_addr | input | 6 | Read-back word address |
| rd_data | output | 32 | Read-back word |

## Verification
The assertions check several properties on every cycle:
- `done` is a single-cycle pulse that coincides with `busy` falling.
- A stalled request holds its select and data.
- A `start` during FILL never re-enters ARM.
- The word counter stays in range.
- The RAM index advances by one per auto-incremented data write and never stores out of range.

Only the bench scenarios can show the following:
- The actual tap pattern and the reserved zero half of word 59.
- The exact 63-cycle latency.
- The opening and closing index values.
- That stalled and double-started runs leave identical RAM contents.

// File: rtl/nnc_pkg.sv
package nnc_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARM   = 2'd1,
        SQ_FILL  = 2'd2,
        SQ_CLEAR = 2'd3
    } seq_state_t;
endpackage

// File: rtl/nnc_word_gen.sv
module nnc_word_gen #(
    parameter int PHASES = 17,
    parameter int TAPS   = 7,
    parameter int CENTER = 3,
    parameter int COEF_W = 16,
    parameter logic [COEF_W-1:0] UNITY = 16'h0800,
    parameter logic [COEF_W-1:0] ZERO  = 16'h3000,
    parameter int AW     = 6
) (
    input  logic [AW-1:0]       word_idx,
    output logic [2*COEF_W-1:0] word
);
    localparam int NCOEF = PHASES * TAPS;
    localparam int CI_W  = AW + 1;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [CI_W-1:0] ci;
        logic [CI_W-1:0] tap;
        assign ci  = {word_idx, 1'b0} + CI_W'(h);
        assign tap = ci % CI_W'(TAPS);
        assign word[h*COEF_W +: COEF_W] =
            (ci >= CI_W'(NCOEF)) ? '0 :
            (tap == CI_W'(CENTER)) ? UNITY : ZERO;
    end
endmodule

// File: rtl/nnc_sequencer.sv
module nnc_sequencer
    import nnc_pkg::*;
#(
    parameter int NWORDS      = 60,
    parameter int AW          = 6,
    parameter int DW          = 32,
    parameter int AUTOINC_BIT = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rdy,
    input  logic [DW-1:0] fill_word,
    output logic [AW-1:0] word_idx,
    output logic          wr,
    output logic          sel,
    output logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done
);
    seq_state_t state_q, state_d;
    logic [AW-1:0] cnt_q;
    logic          done_q;
    logic          accept;
    logic          last_word;

    assign accept    = wr && rdy;
    assign last_word = (cnt_q == AW'(NWORDS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (start) state_d = SQ_ARM;
            SQ_ARM:   if (accept) state_d = SQ_FILL;
            SQ_FILL:  if (accept && last_word) state_d = SQ_CLEAR;
            SQ_CLEAR: if (accept) state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == SQ_CLEAR) && accept;
            if (state_q == SQ_ARM)
                cnt_q <= '0;
            else if (state_q == SQ_FILL && accept)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        wr    = 1'b0;
        sel   = 1'b0;
        wdata = '0;
        unique case (state_q)
            SQ_IDLE:  ;
            SQ_ARM:  begin wr = 1'b1; wdata = DW'(1) << AUTOINC_BIT; end
            SQ_FILL: begin wr = 1'b1; sel = 1'b1; wdata = fill_word; end
            SQ_CLEAR: wr = 1'b1;
            default: ;
        endcase
    end

    assign word_idx = cnt_q;
    assign busy     = (state_q != SQ_IDLE);
    assign done     = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6
    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_FILL && start) |=> (state_q != SQ_ARM)); // R7
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rdy) |=> (wr && $stable(sel) && $stable(wdata))); // R8
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_FILL) |-> (cnt_q < AW'(NWORDS))); // R3
endmodule

// File: rtl/nnc_coef_ram.sv
module nnc_coef_ram #(
    parameter int NWORDS      = 60,
    parameter int AW          = 6,
    parameter int DW          = 32,
    parameter int AUTOINC_BIT = 10,
    parameter int IW          = AUTOINC_BIT + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          wr,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    output logic          rdy,
    output logic [IW-1:0] idx_value,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [NWORDS];
    logic [AW-1:0] idx_q;
    logic          ainc_q;
    logic          wr_ok;
    logic          idx_unused;

    assign rdy   = !stall;
    assign wr_ok = wr && rdy;
    assign idx_unused = ^{wdata[DW-1:AUTOINC_BIT+1], wdata[AUTOINC_BIT-1:AW]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ainc_q <= 1'b0;
        end else if (wr_ok) begin
            if (!sel) begin
                idx_q  <= wdata[AW-1:0];
                ainc_q <= wdata[AUTOINC_BIT];
            end else if (ainc_q) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && sel && idx_q < AW'(NWORDS))
            mem[idx_q] <= wdata;
    end

    assign idx_value = IW'(idx_q) | (IW'(ainc_q) << AUTOINC_BIT);
    assign rd_data   = (rd_addr < AW'(NWORDS)) ? mem[rd_addr] : '0;

    AST_AUTOINC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel && ainc_q) |=> (idx_q == AW'($past(idx_q) + 1'b1))); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel) |-> (idx_q < AW'(NWORDS))); // R9
endmodule

// File: rtl/nn_coef_loader.sv
module nn_coef_loader #(
    parameter int PHASES      = 17,
    parameter int TAPS        = 7,
    parameter int CENTER      = 3,
    parameter int COEF_W      = 16,
    parameter int AUTOINC_BIT = 10,
    localparam int NCOEF      = PHASES * TAPS,
    localparam int NWORDS     = (NCOEF + 1) / 2,
    localparam int AW         = $clog2(NWORDS),
    localparam int DW         = 2 * COEF_W,
    localparam int IW         = AUTOINC_BIT + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ram_stall,
    output logic          busy,
    output logic          done,
    output logic          bus_wr,
    output logic          bus_sel,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_rdy,
    output logic [IW-1:0] idx_value,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [AW-1:0] word_idx;
    logic [DW-1:0] fill_word;

    nnc_word_gen #(
        .PHASES(PHASES), .TAPS(TAPS), .CENTER(CENTER), .COEF_W(COEF_W), .AW(AW)
    ) u_gen (
        .word_idx(word_idx),
        .word    (fill_word)
    );

    nnc_sequencer #(
        .NWORDS(NWORDS), .AW(AW), .DW(DW), .AUTOINC_BIT(AUTOINC_BIT)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rdy      (bus_rdy),
        .fill_word(fill_word),
        .word_idx (word_idx),
        .wr       (bus_wr),
        .sel      (bus_sel),
        .wdata    (bus_wdata),
        .busy     (busy),
        .done     (done)
    );

    nnc_coef_ram #(
        .NWORDS(NWORDS), .AW(AW), .DW(DW), .AUTOINC_BIT(AUTOINC_BIT), .IW(IW)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (ram_stall),
        .wr       (bus_wr),
        .sel      (bus_sel),
        .wdata    (bus_wdata),
        .rdy      (bus_rdy),
        .idx_value(idx_value),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/sim_nn_coef_loader.sv
`timescale 1ns/100ps
module sim_nn_coef_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ram_stall = 1'b0;
    logic        busy, done, bus_wr, bus_sel, bus_rdy;
    logic [31:0] bus_wdata, rd_data;
    logic [10:0] idx_value;
    logic [5:0]  rd_addr = '0;

    always #2.5 clk = ~clk;

    nn_coef_loader u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ram_stall(ram_stall),
        .busy(busy), .done(done), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .idx_value(idx_value),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int checks = 0, fails = 0;
    int n_idx, n_data, n_done, data_err;
    logic [31:0] first_idx, last_idx;
    int cyc = 0;
    logic [7:0] lfsr = 8'h5a;

    typedef struct packed { logic [5:0] addr; logic [31:0] word; } vec_t;
    localparam vec_t SPOT [10] = '{
        '{6'd0,  32'h30003000}, '{6'd1,  32'h08003000}, '{6'd2,  32'h30003000},
        '{6'd3,  32'h30003000}, '{6'd5,  32'h30000800}, '{6'd8,  32'h08003000},
        '{6'd29, 32'h08003000}, '{6'd57, 32'h08003000}, '{6'd58, 32'h30003000},
        '{6'd59, 32'h00003000}
    };

    function automatic logic [31:0] exp_word(int w);
        logic [31:0] r = '0;
        for (int h = 0; h < 2; h++) begin
            int i = 2 * w + h;
            if (i < 119) r[h*16 +: 16] = (i % 7 == 3) ? 16'h0800 : 16'h3000;
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (rst_n && bus_wr && bus_rdy) begin
            if (bus_sel) begin
                if (bus_wdata !== exp_word(n_data)) data_err++;
                n_data++;
            end else begin
                if (n_idx == 0) first_idx = bus_wdata;
                last_idx = bus_wdata;
                n_idx++;
            end
        end
        if (rst_n && done) n_done++;
    end

    task automatic run_fill(bit stalls, bit restart, string tag);
        int lat = 0;
        n_idx = 0; n_data = 0; n_done = 0; data_err = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check({tag, " R6 busy after start"}, 32'(busy), 32'd1);
        lat = 1;
        while (!done && lat < 3000) begin
            if (restart && lat == 6) start = 1'b1;
            else start = 1'b0;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            ram_stall = stalls ? lfsr[0] : 1'b0;
            @(negedge clk);
            lat++;
        end
        start = 1'b0; ram_stall = 1'b0;
        if (!stalls) check({tag, " R6 latency"}, 32'(lat), 32'd63);
        check({tag, " R6 busy low with done"}, 32'(busy), 32'd0);
        check({tag, " R2 first index value"}, first_idx, 32'h400);
        check({tag, " R5 last index value"}, last_idx, 32'h0);
        check({tag, " R7 index write count"}, 32'(n_idx), 32'd2);
        check({tag, " R3 data write count"}, 32'(n_data), 32'd60);
        check({tag, " R3 R8 streamed words"}, 32'(data_err), 32'd0);
        check({tag, " R5 index reg cleared"}, 32'(idx_value), 32'd0);
        @(negedge clk);
        check({tag, " R6 done single cycle"}, 32'(done), 32'd0);
        check({tag, " R7 done count"}, 32'(n_done), 32'd1);
    endtask

    task automatic readback_all(string tag);
        int bad = 0;
        for (int w = 0; w < 60; w++) begin
            rd_addr = 6'(w);
            #0.5;
            if (rd_data !== exp_word(w)) bad++;
        end
        check({tag, " R9 R10 full readback mismatches"}, 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy at reset", 32'(busy), 32'd0);
        check("R1 done at reset", 32'(done), 32'd0);
        check("R1 bus_wr at reset", 32'(bus_wr), 32'd0);
        check("R1 index at reset", 32'(idx_value), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_fill(1'b0, 1'b0, "plain");
        for (int k = 0; k < 10; k++) begin
            rd_addr = SPOT[k].addr;
            #0.5;
            if (SPOT[k].addr == 6'd59) check("R4 reserved upper half", rd_data, SPOT[k].word);
            else check("R3 R10 spot word", rd_data, SPOT[k].word);
        end
        readback_all("plain");

        run_fill(1'b1, 1'b0, "stalled");
        readback_all("stalled R8");

        run_fill(1'b0, 1'b1, "restart");
        readback_all("restart R7");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule